// File: doc/BRIEF.md
# Raw ATM Cell Transmitter with OAM CRC-10 Insertion

This block takes raw ATM cells prepared by software, 52 bytes each (a 4-byte header followed by a 48-byte payload, with no header check byte), and sends them as 53-byte cells over an 8-bit cell-level handshake toward a PHY. The block puts a placeholder byte of 0x00 in the header check slot. The PHY is expected to replace that byte with the real value.

When a cell is marked for CRC insertion, the block computes a CRC-10 over its payload while the cell is being collected. It then writes the result into the last 10 payload bits, which is the form that OAM cells use. Cells marked otherwise leave the block byte for byte as supplied. The input is a valid/ready byte stream with a start-of-cell marker. The block holds a whole cell internally and only begins a cell in a cycle where the PHY signals that it has room. Once a cell has started, all 53 bytes go out back to back.

Top module: `oamc_raw_cell_tx`

## Requirements
- R1: Each transmitted cell is 53 consecutive cycles with `tx_valid` high. `tx_soc` is high only on the first of them. Output bytes 0 to 3 are the four supplied header bytes in order, and output bytes 5 to 52 carry payload bytes 0 to 47.
- R2: Output byte 4, the header check slot, is always 0x00.
- R3: For a cell whose CRC flag was 0, all 48 payload bytes are sent exactly as supplied.
- R4: For a cell whose CRC flag was 1, the CRC value C is the remainder of M(x)·x^10 divided by x^10+x^9+x^5+x^4+x+1. M is the first 374 payload bits, taken most significant bit first starting from payload byte 0, and the remainder starts from zero. C[9:8] replaces bits [1:0] of payload byte 46, and C[7:0] replaces payload byte 47. Bits [7:2] of byte 46 and payload bytes 0 to 45 are unchanged.
- R5: For a cell whose CRC flag was 1, the 384 transmitted payload bits, read as a polynomial, are divisible by x^10+x^9+x^5+x^4+x+1.
- R6: A cell begins only on a clock edge at which `tx_clav` is high. Once a cell has begun, the level of `tx_clav` has no effect on it.
- R7: `in_ready` is high while a cell is being collected. It goes low after the 52nd byte is accepted and stays low until the clock edge that follows the last output byte.
- R8: The CRC flag of a cell is the value of `in_crc_en` on the byte that carries `in_first`. The value of `in_crc_en` on the other bytes is ignored.
- R9: A byte accepted without `in_first` when no cell is being collected is discarded and produces no output.
- R10: A byte with `in_first` that arrives while a cell is partly collected restarts collection with that byte. The earlier partial cell is discarded.
- R11: While reset is held and after it is released, `tx_valid` and `tx_soc` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| in_first | input | 1 | Marks the first header byte of a cell |
| in_data | input | 8 | Input byte |
| in_crc_en | input | 1 | CRC insertion flag, sampled with the marked byte |
| tx_clav | input | 1 | PHY can take a cell |
| tx_valid | output | 1 | Output byte valid |
| tx_soc | output | 1 | First byte of an output cell |
| tx_data | output | 8 | Output byte |

## Verification
The checker assumes that `tx_clav` and the input stream are synchronous to `clk` and are known whenever reset is released. It also assumes that a new cell can never follow the previous one without a gap, which is true because 52 new bytes must be collected first. The bench drives every input one nanosecond after each rising edge, so it never changes an input near an edge. It lowers and raises `tx_clav` at random both between cells and in the middle of cells, which exercises the claim that a started cell ignores that signal.

// File: rtl/oamc_pkg.sv
`timescale 1ns/1ps
package oamc_pkg;
    localparam int DEF_HDR_BYTES = 4;
    localparam int DEF_PAY_BYTES = 48;
    localparam int CRC_W         = 10;
    localparam logic [CRC_W-1:0] CRC_POLY = 10'h233;
    // message bits held in the second-to-last payload byte
    localparam int CRC_PART_BITS = 16 - CRC_W;

    typedef enum logic {LD_COLLECT = 1'b0, LD_HOLD = 1'b1} ld_state_e;
    typedef enum logic {TX_IDLE = 1'b0, TX_SEND = 1'b1} tx_state_e;

    // Shift nbits of data (MSB first) through the CRC-10 register.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc_in,
                                                   input logic [7:0] data,
                                                   input logic [3:0] nbits);
        logic [CRC_W-1:0] c;
        logic fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(nbits)) begin
                fb = data[7-i] ^ c[CRC_W-1];
                c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/oamc_crc10_acc.sv
`timescale 1ns/1ps
module oamc_crc10_acc
    import oamc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [7:0]       data,
    input  logic [3:0]       nbits,
    output logic [CRC_W-1:0] crc
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d.crc = '0;
        end else if (step) begin
            acc_d.crc = crc_step(acc_q.crc, data, nbits);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign crc = acc_q.crc;
endmodule

// File: rtl/oamc_cell_store.sv
`timescale 1ns/1ps
module oamc_cell_store #(
    parameter int DEPTH = 52,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [DEPTH*8-1:0] flat;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            logic [7:0] byte_d, byte_q;
            always_comb begin
                byte_d = byte_q;
                if (wr_en && (wr_idx == IDX_W'(g))) byte_d = wr_data;
            end
            always_ff @(posedge clk) begin
                byte_q <= byte_d;
            end
            assign flat[g*8 +: 8] = byte_q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = flat[i*8 +: 8];
        end
    end
endmodule

// File: rtl/oamc_load_ctrl.sv
`timescale 1ns/1ps
module oamc_load_ctrl
    import oamc_pkg::*;
#(
    parameter  int HDR_BYTES = DEF_HDR_BYTES,
    parameter  int PAY_BYTES = DEF_PAY_BYTES,
    localparam int IN_BYTES  = HDR_BYTES + PAY_BYTES,
    localparam int IDX_W     = $clog2(IN_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [7:0]       in_data,
    input  logic             crc_en_in,
    input  logic             tx_done,
    output logic             in_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             cell_ready,
    output logic             cell_crc_en,
    output logic             crc_clear,
    output logic             crc_step,
    output logic [3:0]       crc_nbits
);
    localparam int CRC_HI_P = PAY_BYTES - 2;

    typedef struct packed {
        ld_state_e        state;
        logic [IDX_W-1:0] cnt;
        logic             crc_en;
    } ld_t;

    ld_t ld_d, ld_q;
    logic [IDX_W-1:0] pay_idx;

    always_comb begin
        ld_d      = ld_q;
        wr_en     = 1'b0;
        wr_idx    = ld_q.cnt;
        wr_data   = in_data;
        crc_clear = 1'b0;
        crc_step  = 1'b0;
        crc_nbits = 4'd8;
        pay_idx   = ld_q.cnt - IDX_W'(HDR_BYTES);
        in_ready  = (ld_q.state == LD_COLLECT);

        case (ld_q.state)
            LD_COLLECT: begin
                if (in_valid) begin
                    if (in_first) begin
                        wr_en       = 1'b1;
                        wr_idx      = '0;
                        ld_d.cnt    = IDX_W'(1);
                        ld_d.crc_en = crc_en_in;
                        crc_clear   = 1'b1;
                    end else if (ld_q.cnt != '0) begin
                        wr_en    = 1'b1;
                        ld_d.cnt = ld_q.cnt + IDX_W'(1);
                        if (ld_q.cnt >= IDX_W'(HDR_BYTES)) begin
                            crc_step  = (pay_idx <= IDX_W'(CRC_HI_P));
                            crc_nbits = (pay_idx < IDX_W'(CRC_HI_P)) ? 4'd8 : 4'(CRC_PART_BITS);
                        end
                        if (ld_q.cnt == IDX_W'(IN_BYTES - 1)) ld_d.state = LD_HOLD;
                    end
                end
            end
            default: begin
                if (tx_done) begin
                    ld_d.state = LD_COLLECT;
                    ld_d.cnt   = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= '{state: LD_COLLECT, cnt: '0, crc_en: 1'b0};
        else        ld_q <= ld_d;
    end

    assign cell_ready  = (ld_q.state == LD_HOLD);
    assign cell_crc_en = ld_q.crc_en;
endmodule

// File: rtl/oamc_tx_seq.sv
`timescale 1ns/1ps
module oamc_tx_seq
    import oamc_pkg::*;
#(
    parameter  int HDR_BYTES = DEF_HDR_BYTES,
    parameter  int PAY_BYTES = DEF_PAY_BYTES,
    localparam int IN_BYTES  = HDR_BYTES + PAY_BYTES,
    localparam int OUT_BYTES = IN_BYTES + 1,
    localparam int RD_W      = $clog2(IN_BYTES + 1),
    localparam int OIDX_W    = $clog2(OUT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_ready,
    input  logic             tx_clav,
    input  logic             cell_crc_en,
    input  logic [CRC_W-1:0] crc,
    input  logic [7:0]       rd_data,
    output logic [RD_W-1:0]  rd_idx,
    output logic             tx_done,
    output logic             tx_valid,
    output logic             tx_soc,
    output logic [7:0]       tx_data
);
    localparam int HEC_POS    = HDR_BYTES;
    localparam int OUT_CRC_HI = OUT_BYTES - 2;
    localparam int OUT_CRC_LO = OUT_BYTES - 1;

    typedef struct packed {
        tx_state_e         state;
        logic [OIDX_W-1:0] idx;
        logic              valid;
        logic              soc;
        logic [7:0]        data;
    } tx_t;

    tx_t tx_d, tx_q;
    logic [OIDX_W-1:0] sel;
    logic [7:0]        out_byte;

    always_comb begin
        sel = (tx_q.state == TX_SEND) ? tx_q.idx : '0;
        if (sel < OIDX_W'(HDR_BYTES)) rd_idx = RD_W'(sel);
        else                          rd_idx = RD_W'(sel - OIDX_W'(1));

        if (sel == OIDX_W'(HEC_POS)) begin
            out_byte = 8'h00;
        end else if (cell_crc_en && (sel == OIDX_W'(OUT_CRC_HI))) begin
            out_byte = {rd_data[7:CRC_W-8], crc[CRC_W-1:8]};
        end else if (cell_crc_en && (sel == OIDX_W'(OUT_CRC_LO))) begin
            out_byte = crc[7:0];
        end else begin
            out_byte = rd_data;
        end
    end

    always_comb begin
        tx_d    = tx_q;
        tx_done = 1'b0;
        case (tx_q.state)
            TX_IDLE: begin
                tx_d.valid = 1'b0;
                tx_d.soc   = 1'b0;
                if (cell_ready && tx_clav) begin
                    tx_d.state = TX_SEND;
                    tx_d.valid = 1'b1;
                    tx_d.soc   = 1'b1;
                    tx_d.data  = out_byte;
                    tx_d.idx   = OIDX_W'(1);
                end
            end
            default: begin
                if (tx_q.idx == OIDX_W'(OUT_BYTES)) begin
                    tx_done    = 1'b1;
                    tx_d.state = TX_IDLE;
                    tx_d.valid = 1'b0;
                    tx_d.soc   = 1'b0;
                    tx_d.idx   = '0;
                end else begin
                    tx_d.valid = 1'b1;
                    tx_d.soc   = 1'b0;
                    tx_d.data  = out_byte;
                    tx_d.idx   = tx_q.idx + OIDX_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '{state: TX_IDLE, idx: '0, valid: 1'b0, soc: 1'b0, data: 8'h00};
        else        tx_q <= tx_d;
    end

    assign tx_valid = tx_q.valid;
    assign tx_soc   = tx_q.soc;
    assign tx_data  = tx_q.data;
endmodule

// File: rtl/oamc_raw_cell_tx.sv
`timescale 1ns/1ps
module oamc_raw_cell_tx
    import oamc_pkg::*;
#(
    parameter int HDR_BYTES = DEF_HDR_BYTES,
    parameter int PAY_BYTES = DEF_PAY_BYTES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_first,
    input  logic [7:0] in_data,
    input  logic       in_crc_en,
    input  logic       tx_clav,
    output logic       tx_valid,
    output logic       tx_soc,
    output logic [7:0] tx_data
);
    localparam int IN_BYTES = HDR_BYTES + PAY_BYTES;
    localparam int IDX_W    = $clog2(IN_BYTES + 1);

    logic             wr_en, cell_ready, cell_crc_en, tx_done;
    logic             crc_clear, crc_step;
    logic [3:0]       crc_nbits;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;
    logic [CRC_W-1:0] crc;

    oamc_load_ctrl #(.HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)) u_load (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_data(in_data), .crc_en_in(in_crc_en), .tx_done(tx_done),
        .in_ready(in_ready), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cell_ready(cell_ready), .cell_crc_en(cell_crc_en),
        .crc_clear(crc_clear), .crc_step(crc_step), .crc_nbits(crc_nbits)
    );

    oamc_crc10_acc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(crc_clear), .step(crc_step),
        .data(wr_data), .nbits(crc_nbits), .crc(crc)
    );

    oamc_cell_store #(.DEPTH(IN_BYTES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    oamc_tx_seq #(.HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cell_ready(cell_ready), .tx_clav(tx_clav),
        .cell_crc_en(cell_crc_en), .crc(crc), .rd_data(rd_data), .rd_idx(rd_idx),
        .tx_done(tx_done), .tx_valid(tx_valid), .tx_soc(tx_soc), .tx_data(tx_data)
    );
endmodule

// File: rtl/oamc_raw_cell_tx_chk.sv
`timescale 1ns/1ps
module oamc_raw_cell_tx_chk
    import oamc_pkg::*;
#(
    parameter  int HDR_BYTES = DEF_HDR_BYTES,
    parameter  int PAY_BYTES = DEF_PAY_BYTES,
    localparam int OUT_BYTES = HDR_BYTES + PAY_BYTES + 1,
    localparam int CW        = $clog2(OUT_BYTES + 2)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       tx_clav,
    input logic       tx_valid,
    input logic       tx_soc,
    input logic [7:0] tx_data
);
    // index of the byte currently on the output within its cell
    logic [CW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        seen_q <= '0;
        else if (tx_valid) seen_q <= tx_soc ? CW'(1) : seen_q + CW'(1);
        else               seen_q <= '0;
    end

    assert_start_on_clav_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |-> (tx_valid && $past(tx_clav)));

    assert_soc_only_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |-> (seen_q == '0));

    assert_no_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen_q != '0) && (seen_q < CW'(OUT_BYTES))) |-> tx_valid);

    assert_cell_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == CW'(OUT_BYTES)) |-> !tx_valid);

    assert_hec_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_soc && (seen_q == CW'(HDR_BYTES))) |-> (tx_data == 8'h00));

    assert_input_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !in_ready);
endmodule

bind oamc_raw_cell_tx oamc_raw_cell_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .tx_clav(tx_clav),
    .tx_valid(tx_valid), .tx_soc(tx_soc), .tx_data(tx_data)
);

// File: tb/oamc_raw_cell_tx_tb.sv
`timescale 1ns/1ps
module oamc_raw_cell_tx_tb;
    typedef logic [7:0] pay_t [48];

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_first = 1'b0, in_crc_en = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       tx_clav = 1'b0;
    logic       in_ready, tx_valid, tx_soc;
    logic [7:0] tx_data;

    oamc_raw_cell_tx u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_data(in_data), .in_crc_en(in_crc_en),
        .tx_clav(tx_clav), .tx_valid(tx_valid), .tx_soc(tx_soc), .tx_data(tx_data)
    );

    int n_vec = 0, n_bad = 0;
    bit finished = 1'b0;
    int clav_mode = 1; // 0 random, 1 low, 2 high
    logic clav_s = 1'b0;

    logic [7:0] exp_q[$];
    bit         flag_q[$];
    string      tag_q[$];
    logic [7:0] cur_hdr [4];
    pay_t       cur_pay;
    pay_t       got_pay;
    int         pos = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Long division of (first nmsg payload bits, zero-filled to 384) by the generator.
    function automatic logic [9:0] poly_rem(input pay_t p, input int nmsg);
        logic [9:0] r;
        logic b, top;
        r = '0;
        for (int i = 0; i < 384; i++) begin
            b   = (i < nmsg) ? p[i/8][7 - (i%8)] : 1'b0;
            top = r[9];
            r   = {r[8:0], b};
            if (top) r = r ^ 10'h233;
        end
        return r;
    endfunction

    task automatic queue_cell(input bit en, input string tag);
        logic [9:0] c;
        c = poly_rem(cur_pay, 374);
        for (int i = 0; i < 4; i++) exp_q.push_back(cur_hdr[i]);
        exp_q.push_back(8'h00);
        for (int k = 0; k < 48; k++) begin
            if (en && k == 46)      exp_q.push_back({cur_pay[46][7:2], c[9:8]});
            else if (en && k == 47) exp_q.push_back(c[7:0]);
            else                    exp_q.push_back(cur_pay[k]);
        end
        flag_q.push_back(en);
        tag_q.push_back(tag);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit f, input bit en, input int gap);
        logic rdy;
        repeat (gap) begin @(posedge clk); #1; end
        in_valid = 1'b1; in_data = d; in_first = f; in_crc_en = en;
        forever begin
            @(negedge clk); rdy = in_ready;
            @(posedge clk); #1;
            if (rdy) break;
        end
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    task automatic fill_random();
        for (int i = 0; i < 4; i++)  cur_hdr[i] = 8'($urandom);
        for (int k = 0; k < 48; k++) cur_pay[k] = 8'($urandom);
    endtask

    // nbytes < 52 sends a partial cell that is not queued
    task automatic send_cell(input bit en, input string tag, input bit rnd_gap, input int nbytes);
        if (nbytes == 52) queue_cell(en, tag);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] d;
            d = (i < 4) ? cur_hdr[i] : cur_pay[i-4];
            send_byte(d, i == 0, (i == 0) ? en : 1'($urandom), rnd_gap ? int'($urandom % 3) : 0);
        end
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // PHY side
    initial begin
        forever begin
            @(posedge clk); #1;
            case (clav_mode)
                0:       tx_clav = (($urandom % 4) != 0);
                1:       tx_clav = 1'b0;
                default: tx_clav = 1'b1;
            endcase
        end
    end
    always @(posedge clk) clav_s <= tx_clav;

    // Output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                string lab;
                bit crc_cell;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected output byte", 32'(tx_data), 32'h0);
                end else begin
                    crc_cell = flag_q[0];
                    lab = (pos < 4) ? "R1" : (pos == 4) ? "R2" : (crc_cell ? "R4" : "R3");
                    check(tx_soc == (pos == 0), "R1", "start marker", 32'(tx_soc), 32'(pos == 0));
                    if (pos == 0) check(clav_s, "R6", "start without clav", 32'(clav_s), 32'h1);
                    check(!in_ready, "R7", "ready during send", 32'(in_ready), 32'h0);
                    check(tx_data == exp_q[0], lab, $sformatf("byte %0d (%s)", pos, tag_q[0]),
                          32'(tx_data), 32'(exp_q[0]));
                    void'(exp_q.pop_front());
                    if (pos >= 5) got_pay[pos-5] = tx_data;
                    pos++;
                    if (pos == 53) begin
                        if (crc_cell) begin
                            logic [9:0] r;
                            r = poly_rem(got_pay, 384);
                            check(r == 10'h0, "R5", "payload remainder", 32'(r), 32'h0);
                        end
                        void'(flag_q.pop_front());
                        void'(tag_q.pop_front());
                        pos = 0;
                    end
                end
            end else if (pos != 0) begin
                check(1'b0, "R1", "gap inside cell", 32'(tx_valid), 32'h1);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: outputs held during reset
        check(!tx_valid && !tx_soc, "R11", "valid/soc in reset", {tx_valid, tx_soc}, 32'h0);
        check(in_ready, "R11", "ready in reset", 32'(in_ready), 32'h1);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid && !tx_soc, "R11", "valid/soc after reset", {tx_valid, tx_soc}, 32'h0);
        check(in_ready, "R11", "ready after reset", 32'(in_ready), 32'h1);
        @(posedge clk); #1;

        // R6/R7: full cell held while clav stays low
        clav_mode = 1;
        fill_random();
        send_cell(1'b0, "R6 held", 1'b0, 52);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(!tx_valid, "R6", "sent without clav", 32'(tx_valid), 32'h0);
        check(!in_ready, "R7", "ready with cell held", 32'(in_ready), 32'h1 ^ 32'h1);
        clav_mode = 2;
        wait_drain();

        // R4/R5: all-ones payload with CRC
        for (int i = 0; i < 4; i++)  cur_hdr[i] = 8'h10 + 8'(i);
        for (int k = 0; k < 48; k++) cur_pay[k] = 8'hFF;
        send_cell(1'b1, "R4 ones", 1'b0, 52);
        // R3: same payload without CRC
        send_cell(1'b0, "R3 ones", 1'b0, 52);
        wait_drain();

        // R9: stray unmarked bytes are dropped
        for (int i = 0; i < 3; i++) send_byte(8'hA0 + 8'(i), 1'b0, 1'b1, 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(!tx_valid, "R9", "output after stray bytes", 32'(tx_valid), 32'h0);
        check(in_ready, "R9", "ready after stray bytes", 32'(in_ready), 32'h1);
        @(posedge clk); #1;
        fill_random();
        send_cell(1'b0, "R9 after strays", 1'b0, 52);
        wait_drain();

        // R10: a marked byte restarts a partial cell; R8 flag comes from the new marker
        fill_random();
        send_cell(1'b1, "R10 partial", 1'b0, 20);
        fill_random();
        send_cell(1'b0, "R10 restart", 1'b0, 52);
        // R8: flag taken from the marked byte only
        fill_random();
        send_cell(1'b1, "R8 flag set", 1'b1, 52);
        fill_random();
        send_cell(1'b0, "R8 flag clear", 1'b1, 52);
        wait_drain();

        // Random phase: clav toggles, including in mid cell (R6)
        clav_mode = 0;
        for (int n = 0; n < 30; n++) begin
            fill_random();
            send_cell(1'($urandom), "R6 random", 1'b1, 52);
        end
        wait_drain();

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule